// File: doc/BRIEF.md
# Transmit Path Reset Sequencer

This block resets the four sub-blocks of a serial transmitter: clock calibration, PMA, PCS and FEC. A global reset input is held high and then released, and the release starts a sequence. Two 2-bit select inputs choose which sub-blocks take part. A 2-bit mode input chooses whether the chosen sub-blocks are reset one after another or all together. Each sub-block is driven through a reset/acknowledge handshake. The block raises a reset line, waits for the sub-block's acknowledge and then releases it.

The controller waits for a user-ready input before it touches the PCS-side sub-blocks and before it reports completion. A PMA-done flag reports that the PMA-side steps have completed. An overall done flag is brought into the user clock domain through a two-flop synchronizer. Both flags clear asynchronously the moment the global reset rises. Four direct reset inputs each start a one-shot reset of a single sub-block, whatever the mode and selects are set to. A global reset given in the middle of a sequence aborts it, and the next release restarts the sequence from the first step.

Top module: `tx_rst_seq`

## Requirements
- R1: While `glb_rst_i` is high, `done_o` and `pma_done_o` are low, and they clear asynchronously without waiting for a clock edge. A sequence starts when `glb_rst_i` falls after being high.
- R2: Lanes are indexed cal=0, pma=1, pcs=2, fec=3 in `blk_rst_o`/`blk_ack_i`/`dir_rst_i`. `pma_mask_i[0]` selects cal, `pma_mask_i[1]` selects pma, `pcs_mask_i[0]` selects fec and `pcs_mask_i[1]` selects pcs. A lane that is not selected is never reset by the sequence.
- R3: In sequential mode the selected lanes are reset one at a time, in the order cal, pma, pcs, fec. Lanes that are not selected are skipped.
- R4: `mode_i`=2'b11 resets all selected lanes at once. The value 2'b00 and the reserved values 2'b01 and 2'b10 all give sequential behaviour.
- R5: The pcs and fec lanes are not reset while `usr_rdy_i` is low, and `done_o` stays low while `usr_rdy_i` is low.
- R6: `done_o` is driven from the `usr_clk` domain and rises only after every selected lane has released its reset.
- R7: `pma_done_o` rises once the cal and pma steps have finished or were not selected. It is low while a direct reset of the pma lane is in progress.
- R8: A pulse on `dir_rst_i[k]` resets lane k only, once, after the pulse falls. Mode and selects have no effect on it, and `done_o` stays high during it.
- R9: Each lane reset stays high for at least HOLD_CYC cycles and is released only while that lane's acknowledge is high.
- R10: A global reset raised in the middle of a sequence drops every lane reset. After the release, the sequence starts again from its first step.
- R11: After `rst_n`, all lane resets and both done flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| usr_clk | input | 1 | User clock for the overall done flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_rst_i | input | 1 | Global reset request; the falling edge starts a sequence |
| mode_i | input | 2 | 2'b11 all at once; any other value sequential |
| pma_mask_i | input | 2 | [1] pma lane, [0] cal lane |
| pcs_mask_i | input | 2 | [1] pcs lane, [0] fec lane |
| usr_rdy_i | input | 1 | User clock stable |
| dir_rst_i | input | 4 | Direct one-shot reset per lane |
| blk_ack_i | input | 4 | Per-lane reset-complete acknowledge |
| blk_rst_o | output | 4 | Per-lane reset |
| pma_done_o | output | 1 | PMA-side reset complete |
| done_o | output | 1 | Whole transmit reset complete, in the usr_clk domain |

## Verification
A wrong pending or fired bit shows up on `blk_rst_o` as a lane that rises out of order, never rises, or rises alongside another lane in sequential mode. The bench sees it in the rise log within a few cycles of the lane before it finishing. A stuck-busy lane or a lost acknowledge shows up as `done_o` never rising, and the per-vector timeout catches it. A done flag that is set early appears as `done_o` high while some lane reset is still high, and the cycle monitor flags it on the next sample.

// File: rtl/tx_rst_pkg.sv
package tx_rst_pkg;
  localparam int NLANE  = 4;
  localparam int LN_CAL = 0;
  localparam int LN_PMA = 1;
  localparam int LN_PCS = 2;
  localparam int LN_FEC = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} seq_st_e;

  // lane vector from the two select fields
  function automatic logic [NLANE-1:0] lane_sel(input logic [1:0] pma_m, input logic [1:0] pcs_m);
    logic [NLANE-1:0] v;
    v[LN_CAL] = pma_m[0];
    v[LN_PMA] = pma_m[1];
    v[LN_PCS] = pcs_m[1];
    v[LN_FEC] = pcs_m[0];
    return v;
  endfunction

  // only 2'b11 is simultaneous; reserved codes fall back to sequential
  function automatic logic mode_is_single(input logic [1:0] m);
    return (m == 2'b11);
  endfunction

  // isolate the lowest set bit
  function automatic logic [NLANE-1:0] lowest_set(input logic [NLANE-1:0] v);
    return v & (~v + {{(NLANE-1){1'b0}}, 1'b1});
  endfunction
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tx_rst_lane.sv
module tx_rst_lane #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic start_i,
  input  logic ack_i,
  output logic rst_o,
  output logic busy_o,
  output logic fin_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic          held_enough;

  assign held_enough = (cnt >= HOLD_LAST);
  assign fin_o       = active && held_enough && ack_i && !abort_i;
  assign rst_o       = active;
  assign busy_o      = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (abort_i) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (start_i) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end else if (fin_o) begin
      active <= 1'b0;
    end else if (!held_enough) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  release_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_o) && !$past(abort_i)) |-> $past(ack_i));

  // R9
  start_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_o && start_i && !abort_i) |=> rst_o);
endmodule

// File: rtl/tx_rst_ctl.sv
module tx_rst_ctl
  import tx_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             glb_s,
  input  logic             rdy_s,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       pma_mask_i,
  input  logic [1:0]       pcs_mask_i,
  input  logic [NLANE-1:0] busy_i,
  input  logic [NLANE-1:0] fin_i,
  output logic [NLANE-1:0] start_o,
  output logic             abort_o,
  output logic             seq_done_o,
  output logic             pma_flag_o
);
  seq_st_e          state;
  logic [NLANE-1:0] pend;
  logic [NLANE-1:0] fired;
  logic             single_q;
  logic [NLANE-1:0] gate;
  logic [NLANE-1:0] eligible;
  logic [NLANE-1:0] fin_hit;
  logic             all_clear;

  // pcs-side lanes wait for the user clock
  always_comb begin
    gate         = '1;
    gate[LN_PCS] = rdy_s;
    gate[LN_FEC] = rdy_s;
  end

  assign eligible  = pend & ~fired & ~busy_i & gate;
  assign fin_hit   = fin_i & fired;
  assign all_clear = (pend == '0) && rdy_s;
  assign abort_o   = glb_s;

  always_comb begin
    start_o = '0;
    if (state == ST_RUN && !glb_s)
      start_o = single_q ? eligible : (eligible & lowest_set(pend));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= '0;
      fired    <= '0;
      single_q <= 1'b0;
    end else if (glb_s) begin
      state <= ST_ARM;
      pend  <= '0;
      fired <= '0;
    end else begin
      case (state)
        ST_ARM: begin
          state    <= ST_RUN;
          pend     <= lane_sel(pma_mask_i, pcs_mask_i);
          single_q <= mode_is_single(mode_i);
          fired    <= '0;
        end
        ST_RUN: begin
          fired <= (fired | start_o) & ~fin_hit;
          pend  <= pend & ~fin_hit;
          if (all_clear) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      seq_done_o <= 1'b0;
      pma_flag_o <= 1'b0;
    end else if (glb_s) begin
      seq_done_o <= 1'b0;
      pma_flag_o <= 1'b0;
    end else if (state == ST_RUN) begin
      if (pend[LN_PMA:LN_CAL] == '0) pma_flag_o <= 1'b1;
      if (all_clear)                 seq_done_o <= 1'b1;
    end
  end

  // R3
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !single_q) |-> ($countones(fired & pend) <= 1));

  // R3
  seq_start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !single_q |-> $onehot0(start_o));

  // R5
  pcs_wait_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o[LN_PCS] || start_o[LN_FEC]) |-> rdy_s);

  // R6
  done_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done_o) |-> ($past(pend) == '0));

  // R10
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_s |=> (state == ST_ARM && fired == '0 && start_o == '0));
endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq
  import tx_rst_pkg::*;
#(
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       usr_clk,
  input  logic       rst_n,
  input  logic       glb_rst_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] pma_mask_i,
  input  logic [1:0] pcs_mask_i,
  input  logic       usr_rdy_i,
  input  logic [3:0] dir_rst_i,
  input  logic [3:0] blk_ack_i,
  output logic [3:0] blk_rst_o,
  output logic       pma_done_o,
  output logic       done_o
);
  localparam int IN_W = NLANE + 2;

  logic             clr_n;
  logic [IN_W-1:0]  in_s;
  logic             glb_s;
  logic             rdy_s;
  logic [NLANE-1:0] dir_s;
  logic [NLANE-1:0] dir_q;
  logic [NLANE-1:0] dir_evt;
  logic [NLANE-1:0] seq_start;
  logic [NLANE-1:0] lane_start;
  logic [NLANE-1:0] lane_busy;
  logic [NLANE-1:0] lane_fin;
  logic             abort;
  logic             seq_done;
  logic             pma_flag;

  // flags clear the moment the global request rises
  assign clr_n = rst_n & ~glb_rst_i;

  tx_rst_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d_i    ({dir_rst_i, usr_rdy_i, glb_rst_i}),
    .q_o    (in_s)
  );

  assign glb_s = in_s[0];
  assign rdy_s = in_s[1];
  assign dir_s = in_s[IN_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_s;
  end

  assign dir_evt = dir_q & ~dir_s;

  tx_rst_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .glb_s      (glb_s),
    .rdy_s      (rdy_s),
    .mode_i     (mode_i),
    .pma_mask_i (pma_mask_i),
    .pcs_mask_i (pcs_mask_i),
    .busy_i     (lane_busy),
    .fin_i      (lane_fin),
    .start_o    (seq_start),
    .abort_o    (abort),
    .seq_done_o (seq_done),
    .pma_flag_o (pma_flag)
  );

  assign lane_start = seq_start | dir_evt;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    tx_rst_lane #(.HOLD_CYC(HOLD_CYC)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort_i (abort),
      .start_i (lane_start[k]),
      .ack_i   (blk_ack_i[k]),
      .rst_o   (blk_rst_o[k]),
      .busy_o  (lane_busy[k]),
      .fin_o   (lane_fin[k])
    );
  end

  assign pma_done_o = pma_flag & ~lane_busy[LN_PMA];

  tx_rst_sync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk    (usr_clk),
    .arst_n (clr_n),
    .d_i    (seq_done),
    .q_o    (done_o)
  );

  // R1
  done_low_in_rst_chk: assert property (@(posedge usr_clk) disable iff (!rst_n)
    glb_rst_i |-> (!done_o && !pma_done_o));

  // R10
  lanes_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (blk_rst_o == '0));

  // R8
  direct_only_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start == '0 && (lane_busy & ~lane_start) == '0 && dir_evt != '0) |=> (blk_rst_o == $past(dir_evt)));
endmodule

// File: tb/tb_tx_rst_seq.sv
module tb_tx_rst_seq;
  localparam int HOLD = 4;
  localparam int LAT [4] = '{3, 5, 2, 7};

  // {mode, pma_mask, pcs_mask, order nibbles (F = none), rises, peak}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b11, 16'h0123, 3'd4, 3'd1},
    {2'b00, 2'b10, 2'b01, 16'h13FF, 3'd2, 3'd1},
    {2'b00, 2'b01, 2'b10, 16'h02FF, 3'd2, 3'd1},
    {2'b11, 2'b11, 2'b11, 16'h0123, 3'd4, 3'd4},
    {2'b01, 2'b11, 2'b11, 16'h0123, 3'd4, 3'd1},
    {2'b10, 2'b01, 2'b01, 16'h03FF, 3'd2, 3'd1},
    {2'b00, 2'b00, 2'b00, 16'hFFFF, 3'd0, 3'd0},
    {2'b11, 2'b10, 2'b10, 16'h12FF, 3'd2, 3'd2}
  };

  logic       clk = 0, usr_clk = 0, rst_n = 0;
  logic       glb_rst = 0, usr_rdy = 0;
  logic [1:0] mode = 0, pma_m = 0, pcs_m = 0;
  logic [3:0] dir_rst = 0, blk_ack = 0;
  logic [3:0] blk_rst;
  logic       pma_done, done;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  always #13 usr_clk = ~usr_clk;

  tx_rst_seq dut (
    .clk(clk), .usr_clk(usr_clk), .rst_n(rst_n), .glb_rst_i(glb_rst),
    .mode_i(mode), .pma_mask_i(pma_m), .pcs_mask_i(pcs_m), .usr_rdy_i(usr_rdy),
    .dir_rst_i(dir_rst), .blk_ack_i(blk_ack), .blk_rst_o(blk_rst),
    .pma_done_o(pma_done), .done_o(done)
  );

  // sub-block models and monitor, sampled at the falling edge
  int acnt [4] = '{0, 0, 0, 0};
  int wcnt [4] = '{0, 0, 0, 0};
  logic [3:0]  prev_rst = 0;
  logic [15:0] olog = 16'hFFFF;
  int ocnt = 0, peak = 0, width_err = 0, overlap_err = 0;
  bit mon_width = 1, mon_overlap = 0, done_low_seen = 0, pma_low_seen = 0;

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (blk_rst[k] && !prev_rst[k]) begin
        if (ocnt < 4) olog[15-4*ocnt -: 4] = 4'(k);
        ocnt++;
      end
      if (!blk_rst[k] && prev_rst[k] && mon_width && (wcnt[k] < LAT[k] || wcnt[k] < HOLD))
        width_err++;
      wcnt[k] = blk_rst[k] ? wcnt[k] + 1 : 0;
    end
    if ($countones(blk_rst) > peak) peak = $countones(blk_rst);
    if (mon_overlap && done && blk_rst != 0) overlap_err++;
    if (!done) done_low_seen = 1;
    if (!pma_done) pma_low_seen = 1;
    prev_rst = blk_rst;
    for (int k = 0; k < 4; k++) begin
      acnt[k]    = blk_rst[k] ? acnt[k] + 1 : 0;
      blk_ack[k] = blk_rst[k] && (acnt[k] >= LAT[k]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    olog = 16'hFFFF; ocnt = 0; peak = 0; width_err = 0; overlap_err = 0;
  endtask

  task automatic pulse_glb();
    @(negedge clk) glb_rst = 1;
    repeat (3) @(negedge clk);
    clear_log();
    glb_rst = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic wait_rst_bit(input int k, output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (blk_rst[k]) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(blk_rst == 0, "R11 lane resets", blk_rst, 0);
    chk(!done && !pma_done, "R11 done flags", {done, pma_done}, 0);

    usr_rdy = 1;
    mon_overlap = 1;
    for (int v = 0; v < NV; v++) begin
      {mode, pma_m, pcs_m} = VEC[v][27:22];
      pulse_glb();
      wait_done(ok);
      chk(ok, "R6 done reached", ok, 1);
      repeat (20) @(negedge clk);
      // R2 R3 R4 order and concurrency
      chk(olog == VEC[v][21:6], "R3/R4 rise order", olog, VEC[v][21:6]);
      chk(ocnt == int'(VEC[v][5:3]), "R2 lanes reset", ocnt, VEC[v][5:3]);
      chk(peak == int'(VEC[v][2:0]), "R4 peak concurrency", peak, VEC[v][2:0]);
      chk(width_err == 0, "R9 hold and ack", width_err, 0);
      chk(overlap_err == 0, "R6 done while lane reset", overlap_err, 0);
      chk(pma_done, "R7 pma done", pma_done, 1);
    end
    mon_overlap = 0;

    // R1 asynchronous clearing between clock edges
    @(negedge clk); #3 glb_rst = 1; #1;
    chk(!done && !pma_done, "R1 async clear", {done, pma_done}, 0);
    repeat (3) @(negedge clk);
    glb_rst = 0;
    wait_done(ok);

    // R10 abort mid-sequence and restart
    mode = 2'b00; pma_m = 2'b11; pcs_m = 2'b11;
    pulse_glb();
    wait_rst_bit(1, ok);
    mon_width = 0;
    glb_rst = 1;
    repeat (4) @(negedge clk);
    chk(blk_rst == 0, "R10 lanes drop", blk_rst, 0);
    clear_log();
    glb_rst = 0;
    repeat (2) @(negedge clk);
    mon_width = 1;
    wait_done(ok);
    repeat (10) @(negedge clk);
    chk(olog == 16'h0123 && ocnt == 4, "R10 restart order", olog, 16'h0123);

    // R5 user ready gating, R7 pma done ahead of it
    usr_rdy = 0;
    pulse_glb();
    for (int i = 0; i < 200 && !pma_done; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(pma_done, "R7 pma done before ready", pma_done, 1);
    chk(blk_rst[3:2] == 0 && olog == 16'h01FF, "R5 pcs held off", olog, 16'h01FF);
    chk(!done, "R5 done waits", done, 0);
    usr_rdy = 1;
    wait_done(ok);
    repeat (10) @(negedge clk);
    chk(olog == 16'h0123, "R5 resumes after ready", olog, 16'h0123);

    // R8 direct reset on pcs with selects cleared
    mode = 2'b11; pma_m = 2'b00; pcs_m = 2'b00;
    clear_log(); done_low_seen = 0;
    @(negedge clk) dir_rst[2] = 1;
    repeat (2) @(negedge clk);
    dir_rst[2] = 0;
    repeat (30) @(negedge clk);
    chk(olog == 16'h2FFF && ocnt == 1, "R8 only own lane", olog, 16'h2FFF);
    chk(!done_low_seen, "R8 done unaffected", done_low_seen, 0);

    // R7 R8 direct pma reset drops pma done
    clear_log(); pma_low_seen = 0;
    @(negedge clk) dir_rst[1] = 1;
    repeat (2) @(negedge clk);
    dir_rst[1] = 0;
    repeat (30) @(negedge clk);
    chk(olog == 16'h1FFF && pma_low_seen, "R7 pma done dips", olog, 16'h1FFF);
    chk(pma_done && width_err == 0, "R7 pma done returns", pma_done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule